// File: doc/BRIEF.md
# Outbound PCI Window Decoder

This block sits between a local bus and a PCI initiator engine and turns local-bus accesses into PCI addresses and bus commands. It holds up to three outbound windows. Each window register defines the window's position in the upper address byte: a base value, a mask whose set bits are "don't care", and a replacement value. A shared control register gives each window an enable, a space selector (memory or I/O) and a read flavour for memory space.

For every access presented on the access port, the block checks all enabled windows in parallel. The lowest-numbered window that matches wins. Its replacement value is merged into the upper address byte, and a PCI command is chosen from the window's space, the access direction and the programmed read flavour. When no window matches, the block flags a miss and issues no command. Results appear one clock after the access. Software reaches the registers through a plain write-strobe and address port, and read data is also registered.

Top module: `pciwin_decoder`

## Requirements
- R1: After reset, every register reads zero and every access is reported as a miss, because all windows start out disabled.
- R2: Register addresses 0, 1 and 2 select window registers 0, 1 and 2. In a window register, bits [31:24] hold the base, [23:16] the mask and [15:8] the replacement value. Bits [7:0] always read zero. `reg_rdata` shows, one clock later, the contents of the register addressed in the previous cycle, as they were before any write in that cycle.
- R3: Register address 3 selects the control register. Window 0's control nibble sits in bits [27:24], window 1's in [19:16] and window 2's in [11:8]. Every other bit reads zero whatever was written. Within a nibble, bit 3 selects I/O space when it is 1, bits 2:1 set the read flavour, and bit 0 is the enable.
- R4: An access hits a window only if that window's enable is 1 and address bits [31:24] equal the base in every position where the mask bit is 0.
- R5: On a hit, output address bit 24+k equals bit k of the replacement value where mask bit k is 0, and equals the incoming address bit where mask bit k is 1. Bits [23:0] pass through unchanged.
- R6: When several enabled windows match, the lowest-numbered one is used, and `pci_win` reports its index.
- R7: An access that hits no window raises `no_hit` for one cycle and keeps `pci_valid` low. The two flags are never high together.
- R8: For an I/O window the command is 0010 for a read and 0011 for a write, whatever the read-flavour bits hold.
- R9: A write to a memory window always produces 0111. The command 1111 is never issued.
- R10: A read from a memory window produces 0110 for flavour 00, 1110 for 01, 1100 for 10, and 0110 for the reserved flavour 11.
- R11: `pci_valid`, `no_hit`, `pci_addr`, `pci_cmd` and `pci_win` change exactly one clock after an access with `acc_valid` high, and are low or quiet otherwise. An access decodes against the register contents from before a register write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 to 2 are windows, 3 is control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| acc_valid | input | 1 | Local-bus access present |
| acc_write | input | 1 | Access direction, 1 means write |
| acc_addr | input | 32 | Local-bus access address |
| pci_valid | output | 1 | A window hit; address and command are valid |
| pci_addr | output | 32 | Translated PCI address |
| pci_cmd | output | 4 | PCI bus command code |
| pci_win | output | 2 | Index of the winning window |
| no_hit | output | 1 | Access matched no enabled window |

## Verification
A register write and an access can land in the same cycle. The bench provokes this by rewriting the control register, or a window register, in the very cycle an access is presented. Sometimes the write disables or moves the window that would hit, and sometimes it enables one that would not. The behavioural reference applies each write only after it has decoded that cycle's access, so the expected result always follows the old register contents. Overlapping windows are also rewritten while accesses run back to back, which checks priority against changing contents.

// File: rtl/pciwin_pkg.sv
package pciwin_pkg;

  localparam int FIELD_W = 8;
  localparam int CTL_W   = 4;

  typedef struct packed {
    logic [FIELD_W-1:0] base;
    logic [FIELD_W-1:0] mask;
    logic [FIELD_W-1:0] xlat;
  } win_t;

  typedef struct packed {
    logic       io;
    logic [1:0] rd_kind;
    logic       en;
  } ctl_t;

  typedef enum logic [3:0] {
    CMD_IO_RD   = 4'b0010,
    CMD_IO_WR   = 4'b0011,
    CMD_MEM_RD  = 4'b0110,
    CMD_MEM_WR  = 4'b0111,
    CMD_MEM_RDM = 4'b1100,
    CMD_MEM_RDL = 4'b1110
  } pci_cmd_e;

endpackage

// File: rtl/pciwin_regs.sv
module pciwin_regs
  import pciwin_pkg::*;
#(
  parameter int NWIN   = 3,
  parameter int DATA_W = 32,
  parameter int RA_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_wr,
  input  logic [RA_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  output win_t [NWIN-1:0]        win_o,
  output ctl_t [NWIN-1:0]        ctl_o
);

  localparam int WIN_BITS = 3 * FIELD_W;
  localparam int WIN_LSB  = DATA_W - WIN_BITS;
  localparam logic [RA_W-1:0] CFG_SEL = RA_W'(NWIN);

  function automatic logic [DATA_W-1:0] cfg_keep_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NWIN; i++)
      m[DATA_W - FIELD_W*(i+1) +: CTL_W] = '1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CFG_KEEP = cfg_keep_mask();

  logic cfg_we;
  assign cfg_we = reg_wr && (reg_addr == CFG_SEL);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    win_t win_r;
    ctl_t ctl_r;

    always_ff @(posedge clk) begin
      if (rst)
        win_r <= '0;
      else if (reg_wr && reg_addr == RA_W'(g))
        win_r <= reg_wdata[DATA_W-1 -: WIN_BITS];
    end

    always_ff @(posedge clk) begin
      if (rst)
        ctl_r <= '0;
      else if (cfg_we)
        ctl_r <= reg_wdata[DATA_W - FIELD_W*(g+1) +: CTL_W];
    end

    assign win_o[g] = win_r;
    assign ctl_o[g] = ctl_r;
  end

  logic [DATA_W-1:0] cfg_view;
  always_comb begin
    cfg_view = '0;
    for (int i = 0; i < NWIN; i++)
      cfg_view[DATA_W - FIELD_W*(i+1) +: CTL_W] = ctl_o[i];
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NWIN; i++)
      if (reg_addr == RA_W'(i))
        rd_next = {win_o[i], {WIN_LSB{1'b0}}};
    if (reg_addr == CFG_SEL)
      rd_next = cfg_view;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  p_cfg_reserved_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_addr) == CFG_SEL) |-> ((reg_rdata & ~CFG_KEEP) == '0));

  p_win_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_addr) < CFG_SEL) |-> (reg_rdata[WIN_LSB-1:0] == '0));

endmodule

// File: rtl/pciwin_match.sv
module pciwin_match
  import pciwin_pkg::*;
#(
  parameter int NWIN   = 3,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2
) (
  input  win_t [NWIN-1:0]   win_i,
  input  ctl_t [NWIN-1:0]   ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NWIN-1:0]   grant_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output ctl_t              ctl_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int LOW_W = ADDR_W - FIELD_W;

  logic [FIELD_W-1:0] upper;
  logic [NWIN-1:0]    match;
  win_t               sel_win;

  assign upper = addr_i[ADDR_W-1 -: FIELD_W];

  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    assign match[g] = ctl_i[g].en &&
                      (((upper ^ win_i[g].base) & ~win_i[g].mask) == '0);
  end

  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    sel_win = '0;
    ctl_o   = '0;
    for (int i = NWIN-1; i >= 0; i--) begin
      if (match[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        idx_o   = IDX_W'(i);
        sel_win = win_i[i];
        ctl_o   = ctl_i[i];
      end
    end
  end

  assign hit_o  = |match;
  assign addr_o = {(sel_win.xlat & ~sel_win.mask) | (upper & sel_win.mask),
                   addr_i[LOW_W-1:0]};

endmodule

// File: rtl/pciwin_cmd.sv
module pciwin_cmd
  import pciwin_pkg::*;
(
  input  ctl_t       ctl_i,
  input  logic       wr_i,
  output logic [3:0] cmd_o
);

  always_comb begin
    if (ctl_i.io) begin
      cmd_o = wr_i ? CMD_IO_WR : CMD_IO_RD;
    end else if (wr_i) begin
      cmd_o = CMD_MEM_WR;
    end else begin
      unique case (ctl_i.rd_kind)
        2'b01:   cmd_o = CMD_MEM_RDL;
        2'b10:   cmd_o = CMD_MEM_RDM;
        default: cmd_o = CMD_MEM_RD;
      endcase
    end
  end

endmodule

// File: rtl/pciwin_decoder.sv
module pciwin_decoder
  import pciwin_pkg::*;
#(
  parameter int NWIN   = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RA_W   = $clog2(NWIN + 1),
  parameter int IDX_W  = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              pci_valid,
  output logic [ADDR_W-1:0] pci_addr,
  output logic [3:0]        pci_cmd,
  output logic [IDX_W-1:0]  pci_win,
  output logic              no_hit
);

  localparam int LOW_W = ADDR_W - FIELD_W;

  win_t [NWIN-1:0]   win;
  ctl_t [NWIN-1:0]   ctl;
  logic [NWIN-1:0]   grant;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  ctl_t              sel_ctl;
  logic [ADDR_W-1:0] xaddr;
  logic [3:0]        cmd;

  pciwin_regs #(.NWIN(NWIN), .DATA_W(DATA_W), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_o(win), .ctl_o(ctl)
  );

  pciwin_match #(.NWIN(NWIN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
    .win_i(win), .ctl_i(ctl), .addr_i(acc_addr), .grant_o(grant),
    .hit_o(hit), .idx_o(idx), .ctl_o(sel_ctl), .addr_o(xaddr)
  );

  pciwin_cmd u_cmd (.ctl_i(sel_ctl), .wr_i(acc_write), .cmd_o(cmd));

  always_ff @(posedge clk) begin
    if (rst) begin
      pci_valid <= 1'b0;
      no_hit    <= 1'b0;
      pci_addr  <= '0;
      pci_cmd   <= '0;
      pci_win   <= '0;
    end else begin
      pci_valid <= acc_valid && hit;
      no_hit    <= acc_valid && !hit;
      if (acc_valid && hit) begin
        pci_addr <= xaddr;
        pci_cmd  <= cmd;
        pci_win  <= idx;
      end
    end
  end

  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(pci_valid && no_hit));

  p_result_needs_access_r11: assert property (@(posedge clk) disable iff (rst)
    (pci_valid || no_hit) |-> $past(acc_valid));

  p_never_mwi_r9: assert property (@(posedge clk) disable iff (rst)
    pci_valid |-> (pci_cmd != 4'b1111));

  p_direction_r9: assert property (@(posedge clk) disable iff (rst)
    pci_valid |-> (pci_cmd[0] == $past(acc_write)));

  p_low_passthru_r5: assert property (@(posedge clk) disable iff (rst)
    pci_valid |-> (pci_addr[LOW_W-1:0] == $past(acc_addr[LOW_W-1:0])));

endmodule

// File: tb/pciwin_decoder_test.sv
module pciwin_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        pci_valid;
  logic [31:0] pci_addr;
  logic [3:0]  pci_cmd;
  logic [1:0]  pci_win;
  logic        no_hit;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit started = 0;

  always #2 clk = ~clk;

  pciwin_decoder uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .pci_valid(pci_valid),
    .pci_addr(pci_addr), .pci_cmd(pci_cmd), .pci_win(pci_win), .no_hit(no_hit)
  );

  // behavioural reference
  logic [23:0] m_win [3];
  logic [3:0]  m_ctl [3];
  logic [31:0] e_rdata = '0, e_addr = '0;
  logic        e_pv = 0, e_nh = 0;
  logic [3:0]  e_cmd = '0;
  logic [1:0]  e_win = '0;

  function automatic logic [31:0] ref_view(input logic [1:0] a);
    if (a == 2'd3) return {4'h0, m_ctl[0], 4'h0, m_ctl[1], 4'h0, m_ctl[2], 8'h00};
    return {m_win[a], 8'h00};
  endfunction

  function automatic logic [3:0] ref_cmd(input logic [3:0] c, input logic wr);
    if (c[3]) return wr ? 4'h3 : 4'h2;
    if (wr) return 4'h7;
    if (c[2:1] == 2'b01) return 4'hE;
    if (c[2:1] == 2'b10) return 4'hC;
    return 4'h6;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin m_win[i] = '0; m_ctl[i] = '0; end
      e_rdata = '0; e_pv = 0; e_nh = 0;
    end else begin
      e_rdata = ref_view(reg_addr);
      e_pv = 0; e_nh = 0;
      if (acc_valid) begin
        for (int i = 0; i < 3; i++) begin
          logic [7:0] b, m, x;
          b = m_win[i][23:16]; m = m_win[i][15:8]; x = m_win[i][7:0];
          if (!e_pv && m_ctl[i][0] && (((acc_addr[31:24] ^ b) & ~m) == 8'h0)) begin
            e_pv = 1;
            e_win = 2'(i);
            e_addr = {(x & ~m) | (acc_addr[31:24] & m), acc_addr[23:0]};
            e_cmd = ref_cmd(m_ctl[i], acc_write);
          end
        end
        e_nh = !e_pv;
      end
      if (reg_wr) begin
        if (reg_addr == 2'd3) begin
          m_ctl[0] = reg_wdata[27:24]; m_ctl[1] = reg_wdata[19:16]; m_ctl[2] = reg_wdata[11:8];
        end else m_win[reg_addr] = reg_wdata[31:8];
      end
    end
    started = 1;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("reg_rdata", reg_rdata, e_rdata);
      chk("pci_valid", 32'(pci_valid), 32'(e_pv));
      chk("no_hit", 32'(no_hit), 32'(e_nh));
      if (e_pv) begin
        chk("pci_addr", pci_addr, e_addr);
        chk("pci_cmd", 32'(pci_cmd), 32'(e_cmd));
        chk("pci_win", 32'(pci_win), 32'(e_win));
      end
    end
  end

  task automatic cyc(input logic w, input logic [1:0] a, input logic [31:0] d,
                     input logic av, input logic aw, input logic [31:0] aa);
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d;
    acc_valid = av; acc_write = aw; acc_addr = aa;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    cyc(1, a, d, 0, 0, 0);
  endtask

  task automatic acc(input logic aw, input logic [31:0] aa);
    cyc(0, reg_addr, 0, 1, aw, aa);
  endtask

  task automatic idle();
    cyc(0, reg_addr, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    phase = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 4; a++) cyc(0, 2'(a), 0, 1, a[0], 32'h1234_5678 * (a + 1));
    idle();

    phase = "R2";
    wreg(0, 32'hABF0_12FF);
    wreg(1, 32'h1122_33CC);
    wreg(2, 32'hFFFF_FFFF);
    for (int a = 0; a < 3; a++) cyc(0, 2'(a), 0, 0, 0, 0);
    idle();

    phase = "R3";
    wreg(3, 32'hFFFF_FFFF);
    cyc(0, 3, 0, 0, 0, 0);
    idle();
    wreg(3, 32'h0000_0000);
    cyc(0, 3, 0, 0, 0, 0);
    idle();

    phase = "R4";
    wreg(0, 32'h400F_8000);
    wreg(1, 32'h2000_5500);
    wreg(2, 32'h6000_7700);
    wreg(3, 32'h0100_0000);
    acc(0, 32'h4512_3456);
    acc(0, 32'h5000_0000);
    acc(0, 32'h2000_0001);
    acc(0, 32'h4F00_0010);

    phase = "R5";
    wreg(0, 32'hC03C_A500);
    acc(1, 32'hC000_00AA);
    acc(0, 32'hFC12_3456);
    acc(0, 32'hF0FF_FFFF);

    phase = "R6";
    wreg(1, 32'h00FF_3300);
    wreg(3, 32'h0101_0100);
    acc(0, 32'hC0AB_CDEF);
    acc(0, 32'h9900_0000);
    wreg(3, 32'h0001_0100);
    acc(0, 32'hC0AB_CDEF);

    phase = "R7";
    wreg(3, 32'h0000_0000);
    acc(0, 32'hC000_0000);
    acc(1, 32'h0000_0000);
    idle();

    phase = "R8";
    wreg(0, 32'h1000_2000);
    for (int k = 0; k < 4; k++) begin
      wreg(3, {4'h0, 4'b1001 | 4'(k << 1), 24'h0});
      acc(0, 32'h1000_0100);
      acc(1, 32'h1000_0200);
    end

    phase = "R9";
    for (int k = 0; k < 4; k++) begin
      wreg(3, {4'h0, 4'b0001 | 4'(k << 1), 24'h0});
      acc(1, 32'h1000_0300);
    end

    phase = "R10";
    for (int k = 0; k < 4; k++) begin
      wreg(3, {4'h0, 4'b0001 | 4'(k << 1), 24'h0});
      acc(0, 32'h1000_0400);
    end

    phase = "R11";
    cyc(1, 3, 32'h0000_0000, 1, 0, 32'h1000_0500);
    acc(0, 32'h1000_0600);
    cyc(1, 3, 32'h0100_0000, 1, 0, 32'h1000_0700);
    acc(0, 32'h1000_0800);
    cyc(1, 0, 32'h2000_3000, 1, 1, 32'h1000_0900);
    acc(1, 32'h2000_0A00);
    idle();

    phase = "R5";
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[2:0] == 3'd0)
        cyc(1, r[4:3], $urandom & 32'hF3FF_FFFF, r[5], r[6], {r[9:8], 6'h0, 24'(r)});
      else
        cyc(0, r[4:3], 0, r[5], r[6], {r[9:8], r[13:12], 4'h0, 24'($urandom)});
    end
    idle();
    idle();
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule